// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It divides the oscillator clock down to a count clock and steps the analog front end through a measurement cycle with four phases. The phases come in a fixed order: auto-zero, signal integrate, reference de-integrate and integrator zero. Each phase is driven as its own one-hot enable, which closes the matching analog switches. The only feedback is the comparator on the integrator output. The comparator is resynchronised and then used three ways: to capture the input polarity, to time the de-integrate ramp, and to end the integrator-zero phase.

The whole cycle always lasts the same number of counts. The reference de-integrate phase varies in length with the input, and the integrator-zero phase has limits of its own. Auto-zero absorbs whatever remains, so the conversion rate never depends on the signal. When de-integration ends, the block latches the count as a magnitude with a sign and an over-range flag, and raises a valid strobe one count wide.

Top module: `dual_slope_sequencer`

## Requirements
- R1: The count clock is the oscillator clock divided by 4. Phase enables and results change only on count-clock edges, so every phase lasts a whole number of counts, and each count is 4 oscillator clocks.
- R2: Exactly one bit of `phase_en` is high at all times. The bit encoding is bit0 auto-zero, bit1 integrate, bit2 de-integrate, bit3 integrator zero. Phases always follow the order auto-zero, integrate, de-integrate, integrator zero, then back to auto-zero.
- R3: The integrate phase lasts exactly 1000 counts.
- R4: The interval from the start of one integrate phase to the start of the next is always 4000 counts (16000 clocks).
- R5: On the last integrate count, the synchronised comparator is sampled. `cmp_in` = 1 means the integrator is above zero. `ref_neg` is set to the inverse of the sampled level and holds for the whole de-integrate phase.
- R6: `cmp_in` passes through two synchroniser flops. De-integration ends at the first count where the synchronised comparator differs from the level sampled on the last integrate count. The reading N is the number of counts completed before that count, and the phase lasts N+1 counts. Readings of 0 to 2000 are reported with `over_range` = 0.
- R7: If no crossing has occurred after 2000 counts, de-integration goes on. A crossing seen at a reading from 2001 to 2090 reports that reading with `over_range` = 1. If there is still no crossing, the phase is forced to end at reading 2090, which is reported with `over_range` = 1.
- R8: After a normal conversion, the integrator-zero phase lasts between 11 and 140 counts. It ends at the first count, at or after the minimum, where the synchronised comparator differs from its level at the end of de-integration, and it is forced to end at the maximum.
- R9: After an over-range conversion, the integrator-zero phase uses the same rule with limits of 31 to 640 counts.
- R10: Auto-zero fills the rest of the cycle, lasting 4000 − 1000 − (N+1) − Z counts, where Z is the integrator-zero length.
- R11: `result`, `result_neg` and `over_range` change only as de-integration ends. `result_valid` is high for exactly one count (4 clocks), starting at that edge. Comparator activity during auto-zero and integrate does not alter the latched result.
- R12: Reset is synchronous and active low. It forces the auto-zero phase and clears the result, the sign, the flag and the strobe. The first auto-zero after reset lasts 1000 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Asynchronous integrator comparator, 1 = above zero |
| phase_en | output | 4 | One-hot phase enables: bit0 auto-zero, bit1 integrate, bit2 de-integrate, bit3 integrator zero |
| ref_neg | output | 1 | Reference polarity select for de-integration |
| result | output | 12 | Latched de-integrate count |
| result_neg | output | 1 | Latched sign, 1 = negative input |
| over_range | output | 1 | Latched over-range flag |
| result_valid | output | 1 | One-count strobe as a new result is latched |

## Verification
The hardest conditions to reach from the ports are the two over-range endings. In one, the comparator crosses inside the narrow 2001 to 2090 window. In the other, it never crosses and the phase is forced to end, which then switches the integrator-zero phase to its wider limits. The bench acts as the integrator ramp. It counts clocks from the observed start of each phase and toggles the comparator on a chosen count. That toggle is placed so that, after two synchroniser flops, the design sees it on exactly the intended count, which lets each reading and each clamp of the zero phase land on a known value.

// File: rtl/dss_pkg.sv
// Shared definitions for the dual-slope sequencer.
// Assumes the phase encoding order matches the bit order of the one-hot enables.
package dss_pkg;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2,
        PH_ZI    = 2'd3
    } phase_t;

    localparam int NUM_PHASES = 4;

endpackage

// File: rtl/dss_prescale.sv
// Count-clock enable generator: a one-clock tick every DIV oscillator clocks.
// Assumes DIV >= 2; the first tick follows DIV clocks after reset release.
module dss_prescale #(
    parameter int DIV = 4,
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    // Free-running divider that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // The tick marks the clock on which the divider wraps.
    always_comb begin
        tick = (div_q == LAST);
    end

endmodule

// File: rtl/dss_sync.sv
// Multi-flop synchroniser for an asynchronous level.
// Assumes STAGES >= 2; the output lags the input by STAGES clocks.
module dss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    // The last stage is the synchronised level.
    always_comb begin
        dout = chain_q[STAGES-1];
    end

endmodule

// File: rtl/dss_phase_ctrl.sv
// Phase state machine with phase and cycle counters, all advanced on the tick.
// Assumes cmp_s is already synchronised; the phase lengths fit within CYCLE_LEN.
module dss_phase_ctrl
    import dss_pkg::*;
#(
    parameter int CYCLE_LEN = 4000,
    parameter int INT_LEN   = 1000,
    parameter int FULL_CNT  = 2000,
    parameter int DEINT_MAX = 2090,
    parameter int ZI_MIN_N  = 11,
    parameter int ZI_MAX_N  = 140,
    parameter int ZI_MIN_O  = 31,
    parameter int ZI_MAX_O  = 640,
    localparam int CW = $clog2(CYCLE_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cmp_s,
    output phase_t        phase,
    output logic          ref_neg,
    output logic          conv_done,
    output logic [CW-1:0] conv_count,
    output logic          conv_ovr
);

    localparam logic [CW-1:0] CYC_LAST   = CW'(CYCLE_LEN - 1);
    localparam logic [CW-1:0] CYC_START  = CW'(CYCLE_LEN - INT_LEN);
    localparam logic [CW-1:0] INT_LAST   = CW'(INT_LEN - 1);
    localparam logic [CW-1:0] FULL_C     = CW'(FULL_CNT);
    localparam logic [CW-1:0] DEINT_LAST = CW'(DEINT_MAX);
    localparam logic [CW-1:0] ZMIN_N_M1  = CW'(ZI_MIN_N - 1);
    localparam logic [CW-1:0] ZMAX_N_M1  = CW'(ZI_MAX_N - 1);
    localparam logic [CW-1:0] ZMIN_O_M1  = CW'(ZI_MIN_O - 1);
    localparam logic [CW-1:0] ZMAX_O_M1  = CW'(ZI_MAX_O - 1);

    logic [CW-1:0] cyc_q;
    logic [CW-1:0] pcnt_q;
    logic          zi_ref_q;
    logic          ovr_run_q;

    logic          crossed;
    logic          int_end;
    logic          deint_end;
    logic          zi_end;
    logic          az_end;
    logic          ovr_now;
    logic [CW-1:0] zi_lo;
    logic [CW-1:0] zi_hi;

    // End conditions of each phase and the limits of the zero phase.
    always_comb begin
        crossed   = (cmp_s == ref_neg);
        zi_lo     = ovr_run_q ? ZMIN_O_M1 : ZMIN_N_M1;
        zi_hi     = ovr_run_q ? ZMAX_O_M1 : ZMAX_N_M1;
        az_end    = (phase == PH_AZ) && (cyc_q == CYC_LAST);
        int_end   = (phase == PH_INT) && (pcnt_q == INT_LAST);
        deint_end = (phase == PH_DEINT) && (crossed || (pcnt_q == DEINT_LAST));
        zi_end    = (phase == PH_ZI) &&
                    (((pcnt_q >= zi_lo) && (cmp_s != zi_ref_q)) || (pcnt_q == zi_hi));
        ovr_now   = !crossed || (pcnt_q > FULL_C);
    end

    // Cycle position; the integrate phase starts at position zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= CYC_START;
        end else if (tick) begin
            cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
        end
    end

    // Phase register and per-phase count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_AZ;
            pcnt_q <= '0;
        end else if (tick) begin
            unique case (phase)
                PH_AZ: begin
                    if (az_end) phase <= PH_INT;
                    pcnt_q <= '0;
                end
                PH_INT: begin
                    if (int_end) begin
                        phase  <= PH_DEINT;
                        pcnt_q <= '0;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                PH_DEINT: begin
                    if (deint_end) begin
                        phase  <= PH_ZI;
                        pcnt_q <= '0;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                PH_ZI: begin
                    if (zi_end) begin
                        phase  <= PH_AZ;
                        pcnt_q <= '0;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                default: begin
                    phase  <= PH_AZ;
                    pcnt_q <= '0;
                end
            endcase
        end
    end

    // Polarity capture at the end of integrate and comparator reference for zeroing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_neg   <= 1'b0;
            zi_ref_q  <= 1'b0;
            ovr_run_q <= 1'b0;
        end else if (tick) begin
            if (int_end) begin
                ref_neg <= ~cmp_s;
            end
            if (deint_end) begin
                zi_ref_q  <= cmp_s;
                ovr_run_q <= ovr_now;
            end
        end
    end

    // Conversion outcome presented on the closing tick.
    always_comb begin
        conv_done  = tick && deint_end;
        conv_count = pcnt_q;
        conv_ovr   = ovr_now;
    end

endmodule

// File: rtl/dss_result.sv
// Result latch and one-count valid strobe.
// Assumes load is asserted only together with a tick.
module dss_result #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [RES_W-1:0] count_in,
    input  logic             neg_in,
    input  logic             ovr_in,
    output logic [RES_W-1:0] result,
    output logic             result_neg,
    output logic             over_range,
    output logic             result_valid
);

    // Hold the last completed conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            result_neg <= 1'b0;
            over_range <= 1'b0;
        end else if (load) begin
            result     <= count_in;
            result_neg <= neg_in;
            over_range <= ovr_in;
        end
    end

    // Strobe rises with the load and falls on the following tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
        end else if (load) begin
            result_valid <= 1'b1;
        end else if (tick) begin
            result_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_slope_sequencer.sv
// Top level of the dual-slope conversion sequencer.
// Assumes cmp_in is asynchronous to clk and that the analog switches decode phase_en directly.
module dual_slope_sequencer
    import dss_pkg::*;
#(
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CYCLE_LEN   = 4000,
    parameter int INT_LEN     = 1000,
    parameter int FULL_CNT    = 2000,
    parameter int DEINT_MAX   = 2090,
    parameter int ZI_MIN_N    = 11,
    parameter int ZI_MAX_N    = 140,
    parameter int ZI_MIN_O    = 31,
    parameter int ZI_MAX_O    = 640,
    localparam int RES_W      = $clog2(CYCLE_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_in,
    output logic [NUM_PHASES-1:0] phase_en,
    output logic                  ref_neg,
    output logic [RES_W-1:0]      result,
    output logic                  result_neg,
    output logic                  over_range,
    output logic                  result_valid
);

    logic             tick;
    logic             cmp_s;
    phase_t           phase;
    logic             conv_done;
    logic [RES_W-1:0] conv_count;
    logic             conv_ovr;

    dss_prescale #(.DIV(DIV)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_in),
        .dout  (cmp_s)
    );

    dss_phase_ctrl #(
        .CYCLE_LEN (CYCLE_LEN),
        .INT_LEN   (INT_LEN),
        .FULL_CNT  (FULL_CNT),
        .DEINT_MAX (DEINT_MAX),
        .ZI_MIN_N  (ZI_MIN_N),
        .ZI_MAX_N  (ZI_MAX_N),
        .ZI_MIN_O  (ZI_MIN_O),
        .ZI_MAX_O  (ZI_MAX_O)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmp_s      (cmp_s),
        .phase      (phase),
        .ref_neg    (ref_neg),
        .conv_done  (conv_done),
        .conv_count (conv_count),
        .conv_ovr   (conv_ovr)
    );

    dss_result #(.RES_W(RES_W)) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .load         (conv_done),
        .count_in     (conv_count),
        .neg_in       (ref_neg),
        .ovr_in       (conv_ovr),
        .result       (result),
        .result_neg   (result_neg),
        .over_range   (over_range),
        .result_valid (result_valid)
    );

    // Decode the phase into one enable per analog switch group.
    for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_en
        assign phase_en[gi] = (phase == phase_t'(gi));
    end

endmodule

// File: rtl/dual_slope_sequencer_chk.sv
// Property checker for the sequencer, attached by bind.
// Assumes phase_en bit order auto-zero, integrate, de-integrate, zero.
module dual_slope_sequencer_chk #(
    parameter int DIV       = 4,
    parameter int CYCLE_LEN = 4000,
    parameter int ZI_MAX_O  = 640,
    parameter int RES_W     = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [3:0]       phase_en,
    input logic             ref_neg,
    input logic [RES_W-1:0] result,
    input logic             result_valid
);

    logic prev_int;
    logic seen_int;
    int   cyc_clks;
    int   zi_clks;

    // Clocks between integrate starts, and clocks spent in the zero phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_int <= 1'b0;
            seen_int <= 1'b0;
            cyc_clks <= 0;
            zi_clks  <= 0;
        end else begin
            prev_int <= phase_en[1];
            if (phase_en[1] && !prev_int) begin
                cyc_clks <= 1;
                seen_int <= 1'b1;
            end else begin
                cyc_clks <= cyc_clks + 1;
            end
            zi_clks <= phase_en[3] ? zi_clks + 1 : 0;
        end
    end

    a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_en) == 1);

    a_r1_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en != $past(phase_en)) |-> $past(tick));

    a_r2_deint_after_int: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_en[2]) |-> $past(phase_en[1]));

    a_r2_az_after_zi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_en[0]) |-> $past(phase_en[3]));

    a_r4_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en[1] && !prev_int && seen_int) |-> (cyc_clks == DIV * CYCLE_LEN));

    a_r5_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en[2] && $past(phase_en[2])) |-> $stable(ref_neg));

    a_r9_zi_bound: assert property (@(posedge clk) disable iff (!rst_n)
        zi_clks <= DIV * ZI_MAX_O);

    a_r11_valid_at_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $rose(phase_en[3]));

    a_r11_result_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $rose(result_valid));

endmodule

bind dual_slope_sequencer dual_slope_sequencer_chk #(
    .DIV       (DIV),
    .CYCLE_LEN (CYCLE_LEN),
    .ZI_MAX_O  (ZI_MAX_O),
    .RES_W     (RES_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .phase_en     (phase_en),
    .ref_neg      (ref_neg),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/dual_slope_sequencer_bench.sv
`timescale 1ns/1ps
module dual_slope_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_in = 1'b0;
    logic [3:0]  phase_en;
    logic        ref_neg;
    logic [11:0] result;
    logic        result_neg;
    logic        over_range;
    logic        result_valid;

    int checks = 0;
    int fails  = 0;

    // Vector: {negative input, crossing count or -1, zero-phase toggle count or -1}
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{0,  500,   50},
        '{1, 1234,    5},
        '{0,    0,   -1},
        '{1, 2000,   20},
        '{0, 2001,   20},
        '{1,   -1,  300},
        '{0, 2050,   -1},
        '{0, 1999,  200}
    };

    always #2.5 clk = ~clk;

    dual_slope_sequencer u_dual_slope_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_in       (cmp_in),
        .phase_en     (phase_en),
        .ref_neg      (ref_neg),
        .result       (result),
        .result_neg   (result_neg),
        .over_range   (over_range),
        .result_valid (result_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full conversion, entered at the first negedge with integrate high.
    task automatic run_vec(input int neg, input int n, input int m);
        int c;
        int exp_res;
        int exp_ovr;
        int zmin;
        int zmax;
        int exp_z;
        int vcnt;
        logic [11:0] held;
        exp_res = (n < 0) ? 2090 : n;
        exp_ovr = ((n < 0) || (n > 2000)) ? 1 : 0;
        zmin = exp_ovr ? 31 : 11;
        zmax = exp_ovr ? 640 : 140;
        if (m < 0) exp_z = zmax;
        else if (m + 1 < zmin) exp_z = zmin;
        else if (m + 1 > zmax) exp_z = zmax;
        else exp_z = m + 1;

        cmp_in = (neg != 0) ? 1'b0 : 1'b1;
        c = 0;
        while (phase_en[1]) begin @(negedge clk); c++; end
        chk("R3 integrate clocks", c, 4000);
        chk("R5 ref_neg at de-integrate", int'(ref_neg), neg);

        c = 0;
        while (phase_en[2]) begin
            if (n >= 0 && c == 4 * n) cmp_in = ~cmp_in;
            @(negedge clk); c++;
        end
        chk("R6 de-integrate clocks", c, 4 * (exp_res + 1));
        chk("R11 valid at de-integrate end", int'(result_valid), 1);
        chk("R6 R7 result", int'(result), exp_res);
        chk("R7 over_range", int'(over_range), exp_ovr);
        chk("R5 result_neg", int'(result_neg), neg);
        chk("R2 zero phase follows", int'(phase_en), 8);

        c = 0;
        vcnt = 0;
        while (phase_en[3]) begin
            if (m >= 0 && c == 4 * m) cmp_in = ~cmp_in;
            if (result_valid) vcnt++;
            @(negedge clk); c++;
        end
        chk("R11 valid width clocks", vcnt, 4);
        if (exp_ovr != 0) chk("R9 zero phase clocks", c, 4 * exp_z);
        else chk("R8 zero phase clocks", c, 4 * exp_z);

        held = result;
        c = 0;
        while (phase_en[0]) begin
            if (c % 400 == 200) cmp_in = ~cmp_in;
            @(negedge clk); c++;
        end
        chk("R10 auto-zero clocks", c, 4 * (3000 - (exp_res + 1) - exp_z));
        chk("R11 result unchanged by comparator in auto-zero", int'(result), int'(held));
        chk("R4 integrate follows auto-zero", int'(phase_en), 2);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk("R12 reset phase", int'(phase_en), 1);
        chk("R12 reset result", int'(result), 0);
        chk("R12 reset valid", int'(result_valid), 0);
        rst_n = 1'b1;

        // First auto-zero after reset.
        c = 0;
        while (phase_en[0]) begin @(negedge clk); c++; end
        chk("R12 first auto-zero clocks", c, 4000);
        chk("R1 count clock divide in first phase", c % 4, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2]);
        end

        // Reset in the middle of de-integration.
        cmp_in = 1'b1;
        repeat (5000) @(negedge clk);
        chk("R2 in de-integrate before reset", int'(phase_en), 4);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 mid-run reset phase", int'(phase_en), 1);
        chk("R12 mid-run reset result", int'(result), 0);
        chk("R12 mid-run reset flag", int'(over_range), 0);
        chk("R12 mid-run reset sign", int'(result_neg) + int'(ref_neg), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R12 auto-zero after release", int'(phase_en), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule